// File: doc/BRIEF.md
# I2C Target with Auto-Incrementing Register Bank

This block is an I2C bus target that gives an external host read and write access to a bank of 8-bit control registers. Both bus lines are synchronized into the core clock domain. SDA is driven through an open-drain enable, so the board must provide the pull-up. Before any data moves, the host sets an internal subaddress pointer. The pointer then steps by one for each data byte, whether the byte is written or read, so one transaction can cover a run of neighbouring registers.

The 7-bit device address has a fixed upper part, 101110 in binary. Its LSB comes from a strap pin, which is sampled on the first clock after the active-low reset is released. With the strap at 0 the write and read address bytes are 0xB8 and 0xB9. With the strap at 1 they are 0xBA and 0xBB. A strap that no source drives is expected to be tied low on the board.

A write transaction is an address with R/W=0, then the subaddress, then any number of data bytes. A read is the combined form: a write of the subaddress, then a repeated START, then an address with R/W=1, then data bytes sent by the target.

Top module: `i2c_regbank_target`

## Requirements
- R1: An address byte whose upper seven bits equal 101110 followed by the latched strap bit is acknowledged by driving SDA low during the ninth SCL clock. Bit 0 of the address byte selects the direction: 0 for write, 1 for read.
- R2: The strap is captured once, on the first clock after reset is released. Changes on the strap input after that have no effect on address matching until the next reset.
- R3: In a write, the byte after the address is loaded into the pointer. Every later byte is acknowledged and stored at the pointer.
- R4: In a read, the target shifts out the register at the pointer, MSB first.
- R5: The pointer advances by one after every data byte, whether written or read.
- R6: The pointer wraps from 0xFF to 0x00.
- R7: The pointer keeps its value across STOP. A read that gives no new subaddress continues from the current pointer.
- R8: When the master answers a read byte with NAK (SDA high), the target releases SDA and stays idle until the next START. After any STOP, SDA is released.
- R9: A non-matching address is not acknowledged. SDA stays released for the rest of that transaction, and no register is written during it.
- R10: A START detected at any point, including in the middle of a byte, restarts address reception with the bit counter cleared.
- R11: The target changes its SDA enable only while SCL is low.
- R12: After reset, SDA is released and every register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strap_i | input | 1 | Device address LSB strap, sampled after reset release |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The assertions assume that the SCL high and low phases each last several core clocks, longer than the synchronizer delay. They also assume that SDA changes only while SCL is low, except for START and STOP. Under these conditions the rule that the SDA enable changes only with SCL low holds after synchronization.

The bench master keeps a quarter period of four clocks and a high phase of eight clocks. It moves SDA only in the middle of the low phase, or deliberately while SCL is high to form START and STOP. The strap changes only between transactions.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SUB,
    ST_WDAT,
    ST_ACK,
    ST_RDAT,
    ST_MACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  // SDA edge while SCL steadily high
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int NUM_REGS = 1 << AW;
  logic [DW-1:0] mem [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  mem[g] <= '0;
      else if (we_i && waddr_i == AW'(g))           mem[g] <= wdata_i;
    end
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter int         AW      = 8,
  parameter logic [5:0] ADDR_HI = 6'b101110
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          strap_i,
  input  logic          sda_s_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [7:0]    rd_data_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic [AW-1:0] ptr_o,
  output logic [2:0]    bit_cnt_o,
  output logic          armed_o,
  output logic          strap_o,
  output logic          sda_oe_o
);
  tgt_state_e state_q, next_q;
  logic [7:0] shreg_q;
  logic       ack_ph_q, nack_q;
  logic [7:0] byte_in;
  logic [6:0] dev_addr;

  assign byte_in  = {shreg_q[6:0], sda_s_i};
  assign dev_addr = {ADDR_HI, strap_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      next_q    <= ST_IDLE;
      shreg_q   <= '0;
      ack_ph_q  <= 1'b0;
      nack_q    <= 1'b0;
      bit_cnt_o <= '0;
      ptr_o     <= '0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      armed_o   <= 1'b0;
      strap_o   <= 1'b0;
      sda_oe_o  <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      if (!armed_o) begin
        armed_o <= 1'b1;
        strap_o <= strap_i;
      end
      if (start_i) begin
        state_q   <= ST_ADDR;
        bit_cnt_o <= '0;
        ack_ph_q  <= 1'b0;
        sda_oe_o  <= 1'b0;
      end else if (stop_i) begin
        state_q   <= ST_IDLE;
        bit_cnt_o <= '0;
        ack_ph_q  <= 1'b0;
        sda_oe_o  <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_SUB, ST_WDAT: begin
            if (scl_rise_i) begin
              shreg_q   <= byte_in;
              bit_cnt_o <= bit_cnt_o + 3'd1;
              if (bit_cnt_o == 3'd7) begin
                if (state_q == ST_ADDR) begin
                  if (byte_in[7:1] == dev_addr) begin
                    state_q <= ST_ACK;
                    next_q  <= byte_in[0] ? ST_RDAT : ST_SUB;
                  end else begin
                    state_q <= ST_IDLE;  // not ours: stay off the bus
                  end
                end else if (state_q == ST_SUB) begin
                  ptr_o   <= byte_in[AW-1:0];
                  state_q <= ST_ACK;
                  next_q  <= ST_WDAT;
                end else begin
                  wr_en_o   <= 1'b1;
                  wr_addr_o <= ptr_o;
                  wr_data_o <= byte_in;
                  ptr_o     <= ptr_o + AW'(1);
                  state_q   <= ST_ACK;
                  next_q    <= ST_WDAT;
                end
              end
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              if (!ack_ph_q) begin
                sda_oe_o <= 1'b1;
                ack_ph_q <= 1'b1;
              end else begin
                ack_ph_q  <= 1'b0;
                bit_cnt_o <= '0;
                if (next_q == ST_RDAT) begin
                  shreg_q  <= rd_data_i;
                  sda_oe_o <= ~rd_data_i[7];
                  ptr_o    <= ptr_o + AW'(1);
                  state_q  <= ST_RDAT;
                end else begin
                  sda_oe_o <= 1'b0;
                  state_q  <= next_q;
                end
              end
            end
          end
          ST_RDAT: begin
            if (scl_fall_i) begin
              if (bit_cnt_o == 3'd7) begin
                sda_oe_o <= 1'b0;
                state_q  <= ST_MACK;
              end else begin
                shreg_q   <= {shreg_q[6:0], 1'b0};
                sda_oe_o  <= ~shreg_q[6];
                bit_cnt_o <= bit_cnt_o + 3'd1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise_i && !ack_ph_q) begin
              nack_q   <= sda_s_i;
              ack_ph_q <= 1'b1;
            end else if (scl_fall_i && ack_ph_q) begin
              ack_ph_q  <= 1'b0;
              bit_cnt_o <= '0;
              if (nack_q) begin
                state_q <= ST_IDLE;
              end else begin
                shreg_q  <= rd_data_i;
                sda_oe_o <= ~rd_data_i[7];
                ptr_o    <= ptr_o + AW'(1);
                state_q  <= ST_RDAT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target #(
  parameter int         REG_AW      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [5:0] ADDR_HI     = 6'b101110
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strap_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en, strap_armed, strap_q;
  logic [REG_AW-1:0] wr_addr, ptr;
  logic [7:0] wr_data, rd_data;
  logic [2:0] bit_cnt;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  i2c_tgt_engine #(.AW(REG_AW), .ADDR_HI(ADDR_HI)) u_engine (
    .clk_i, .rst_ni, .strap_i,
    .sda_s_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det), .rd_data_i(rd_data),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .ptr_o(ptr), .bit_cnt_o(bit_cnt), .armed_o(strap_armed),
    .strap_o(strap_q), .sda_oe_o
  );

  i2c_tgt_regs #(.AW(REG_AW), .DW(8)) u_regs (
    .clk_i, .rst_ni,
    .we_i(wr_en), .waddr_i(wr_addr), .wdata_i(wr_data),
    .raddr_i(ptr), .rdata_o(rd_data)
  );
endmodule

// File: rtl/i2c_tgt_checker.sv
module i2c_tgt_checker #(
  parameter int AW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_s,
  input logic          sda_oe,
  input logic          start_det,
  input logic          stop_det,
  input logic [2:0]    bit_cnt,
  input logic          armed,
  input logic          strap_q,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [AW-1:0] ptr
);
  p_sda_scl_low_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe != $past(sda_oe)) |-> !scl_s);

  p_strap_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(armed)) |-> $stable(strap_q));

  p_start_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> (bit_cnt == 3'd0 && !sda_oe));

  p_stop_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe);

  p_ptr_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> (ptr == AW'(wr_addr + AW'(1))));
endmodule

bind i2c_regbank_target i2c_tgt_checker #(.AW(REG_AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s), .sda_oe(sda_oe_o),
  .start_det(start_det), .stop_det(stop_det), .bit_cnt(bit_cnt),
  .armed(strap_armed), .strap_q(strap_q), .wr_en(wr_en),
  .wr_addr(wr_addr), .ptr(ptr)
);

// File: tb/tb_i2c_regbank_target.sv
module tb_i2c_regbank_target;
  logic clk = 1'b0, rst_n = 1'b0, strap = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_line;
  int n_checks = 0, n_fail = 0;
  logic [7:0] exp_q[$], act_q[$];
  string tag_q[$];
  bit done = 1'b0;

  localparam int Q = 4, H = 8;

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_regbank_target dut (
    .clk_i(clk), .rst_ni(rst_n), .strap_i(strap),
    .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe)
  );

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  // monitor: compare observed bus results against expected queue
  always @(negedge clk) begin
    while (act_q.size() > 0 && exp_q.size() > 0) begin
      logic [7:0] a, e;
      string t;
      a = act_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(a == e, t, a, e);
    end
  end

  task automatic bus_start();
    sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(H);
    sda_m = 1'b0; wt(H);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b1; wt(H);
    sda_m = 1'b1; wt(H);
  endtask

  task automatic send_bit(bit b);
    sda_m = b; wt(Q);
    scl_m = 1'b1; wt(H);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic get_bit(output bit b);
    sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(H / 2);
    b = sda_line; wt(H / 2);
    scl_m = 1'b0; wt(Q);
  endtask

  // driver: pushes expected ACK level, then the observed one
  task automatic put_byte(logic [7:0] v, bit exp_ack, string req);
    bit a;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    exp_q.push_back({7'd0, exp_ack});
    tag_q.push_back(req);
    get_bit(a);
    act_q.push_back({7'd0, a});
  endtask

  task automatic get_byte(logic [7:0] exp, bit last, string req);
    logic [7:0] v;
    bit b;
    exp_q.push_back(exp);
    tag_q.push_back(req);
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    act_q.push_back(v);
    send_bit(last);
  endtask

  task automatic rd_at(logic [7:0] dev, logic [7:0] sub, logic [7:0] exp, string req);
    bus_start();
    put_byte(dev, 1'b0, req);
    put_byte(sub, 1'b0, req);
    bus_start();
    put_byte(dev | 8'h01, 1'b0, req);
    get_byte(exp, 1'b1, req);
    bus_stop();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    wt(5);
    // R12: reset state, SDA released
    chk(sda_oe == 1'b0, "R12 oe after reset", {7'd0, sda_oe}, 8'h00);
    rst_n = 1'b1;
    wt(10);

    // R1 R3 R5: multi-byte write from 0x10
    bus_start();
    put_byte(8'hB8, 1'b0, "R1 addr ack");
    put_byte(8'h10, 1'b0, "R3 sub ack");
    put_byte(8'hA5, 1'b0, "R3 data ack");
    put_byte(8'h3C, 1'b0, "R5 data ack");
    put_byte(8'h7E, 1'b0, "R5 data ack");
    put_byte(8'hC1, 1'b0, "R5 data ack");
    bus_stop();

    // R4 R5 R8: combined read of three bytes, NAK on last
    bus_start();
    put_byte(8'hB8, 1'b0, "R4 addr ack");
    put_byte(8'h10, 1'b0, "R4 sub ack");
    bus_start();
    put_byte(8'hB9, 1'b0, "R1 read addr ack");
    get_byte(8'hA5, 1'b0, "R4 byte0");
    get_byte(8'h3C, 1'b0, "R5 byte1");
    get_byte(8'h7E, 1'b1, "R5 byte2");
    wt(H);
    chk(sda_oe == 1'b0, "R8 released after NAK", {7'd0, sda_oe}, 8'h00);
    bus_stop();

    // R7: read without subaddress continues at 0x13
    bus_start();
    put_byte(8'hB9, 1'b0, "R7 addr ack");
    get_byte(8'hC1, 1'b1, "R7 continued read");
    bus_stop();
    chk(sda_oe == 1'b0, "R8 released after STOP", {7'd0, sda_oe}, 8'h00);

    // R6: wrap 0xFF -> 0x00 on write and read
    bus_start();
    put_byte(8'hB8, 1'b0, "R6 addr ack");
    put_byte(8'hFF, 1'b0, "R6 sub ack");
    put_byte(8'h11, 1'b0, "R6 data ack");
    put_byte(8'h22, 1'b0, "R6 data ack");
    bus_stop();
    bus_start();
    put_byte(8'hB8, 1'b0, "R6 addr ack");
    put_byte(8'hFF, 1'b0, "R6 sub ack");
    bus_start();
    put_byte(8'hB9, 1'b0, "R6 raddr ack");
    get_byte(8'h11, 1'b0, "R6 reg FF");
    get_byte(8'h22, 1'b1, "R6 reg 00 after wrap");
    bus_stop();

    // R9: mismatched address ignored, nothing written
    bus_start();
    put_byte(8'hBA, 1'b1, "R9 no ack for foreign addr");
    put_byte(8'h20, 1'b1, "R9 sda released");
    put_byte(8'h99, 1'b1, "R9 sda released");
    bus_stop();
    rd_at(8'hB8, 8'h20, 8'h00, "R9 reg untouched");

    // R12: untouched register reads zero
    rd_at(8'hB8, 8'h55, 8'h00, "R12 reset value");

    // R10: START mid-byte restarts address phase
    bus_start();
    put_byte(8'hB8, 1'b0, "R10 addr ack");
    put_byte(8'h30, 1'b0, "R10 sub ack");
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bus_start();
    put_byte(8'hB8, 1'b0, "R10 addr ack after abort");
    put_byte(8'h30, 1'b0, "R10 sub ack");
    put_byte(8'h5A, 1'b0, "R10 data ack");
    bus_stop();
    rd_at(8'hB8, 8'h30, 8'h5A, "R10 data after abort");

    // R2: strap change without reset is ignored
    strap = 1'b1;
    wt(10);
    bus_start();
    put_byte(8'hBA, 1'b1, "R2 late strap ignored");
    bus_stop();
    bus_start();
    put_byte(8'hB8, 1'b0, "R2 old address kept");
    bus_stop();

    // R2 R12: new reset captures strap=1
    rst_n = 1'b0;
    wt(5);
    rst_n = 1'b1;
    wt(10);
    bus_start();
    put_byte(8'hB8, 1'b1, "R2 old address dropped");
    bus_stop();
    rd_at(8'hBA, 8'h10, 8'h00, "R2 R12 new address, regs cleared");

    wt(20);
    done = 1'b1;
    chk(exp_q.size() == 0, "scoreboard drained", 8'(exp_q.size()), 8'h00);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule